// File: doc/BRIEF.md
# Outbound Virtual Channel Reservation Unit

This unit keeps the reservation state of every outbound virtual channel of a four-port router. Each port carries three virtual channels, so twelve channels exist. Channel c belongs to link c / 3 and is virtual channel c % 3 on that link. Sixteen requesters share the unit. Requesters 0 to 3 stand for the receive-side routing engines, and requesters 4 to 15 stand for the transmit-side packet senders. Each requester can ask to take a set of channels or to give a set back. Routing logic reads a live busy vector and an owner field for every channel, so adaptive decisions can steer around channels that are already held.

A reserve request carries a channel mask. This lets one packet claim several output channels at once for multicast. The whole mask is granted or none of it is. When requests overlap in the same cycle, a round-robin pointer picks the winners. Release is guarded: only the requester that holds a channel can free it. A wrong release leaves the channel unchanged and raises an error pulse.

Top module: `vc_rsv_unit`

## Requirements
- R1: After reset, every channel is free, every owner field reads 0, and no grant or error pulse is present.
- R2: A reserve request whose mask names only free channels gives a one-cycle grant pulse on the requester's bit in the cycle after the request. In that same cycle, the named channels read busy with owner equal to the requester index. Channel c is bit c of `busy_o` and bits c*4+3..c*4 of `owner_o`.
- R3: If any channel in a reserve mask is busy, that request gets no grant and none of its channels change, including the free ones.
- R4: When reserve masks overlap, requesters are scanned in ascending index order starting at a pointer that wraps around. The pointer is 0 after reset. A request is granted when none of its channels is busy or already taken earlier in the scan. After any grant, the pointer moves to one past the first requester granted in that scan.
- R5: Reserve requests whose masks do not overlap, and whose channels are all free, are all granted in the same cycle.
- R6: A release from the current owner frees the named channels in the cycle after the request.
- R7: A release naming a channel that the requester does not hold (held by another requester, or free) leaves that channel's busy and owner state unchanged. It raises the requester's bit of `rel_err_o` for one cycle, in the cycle after the request.
- R8: A reserve request for a channel in the same cycle as that channel's release is refused. A reserve request in the following cycle is granted.
- R9: A reserve request with an all-zero mask is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_req_i | input | 16 | Reserve request, one bit per requester |
| rsv_mask_i | input | 192 | Reserve channel masks, 12 bits per requester, requester r at bits r*12+11..r*12 |
| rel_req_i | input | 16 | Release request, one bit per requester |
| rel_mask_i | input | 192 | Release channel masks, same layout as rsv_mask_i |
| rsv_gnt_o | output | 16 | One-cycle grant pulse per requester |
| rel_err_o | output | 16 | One-cycle pulse for a release naming a channel not held |
| busy_o | output | 12 | Live reservation status per channel |
| owner_o | output | 48 | Owner index per channel, 4 bits each |

## Verification
Every result is registered once: grants, error pulses, busy bits and owner fields all change at the first rising edge after the request. The bench drives inputs on the falling edge and removes them on the next falling edge, and it samples at that same point, which is exactly one edge after the request. The release-then-reserve case uses two back-to-back cycles, so the refusal in the shared cycle and the grant in the next cycle are both observed. The round-robin checks run straight after reset, so the pointer history is known. A sweep over every channel and requester pair then covers ownership, wrong-owner release and owner release.

// File: rtl/vc_rsv_pkg.sv
package vc_rsv_pkg;
  localparam int DEF_LINKS  = 4;
  localparam int DEF_VCS    = 3;
  localparam int DEF_RX_REQ = 4;

  function automatic int rr_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/vc_rsv_release.sv
module vc_rsv_release #(
  parameter int NUM_REQ = 16,
  parameter int NUM_CH  = 12,
  parameter int IDW     = 4
) (
  input  logic [NUM_REQ-1:0]        rel_req_i,
  input  logic [NUM_REQ*NUM_CH-1:0] rel_mask_i,
  input  logic [NUM_CH-1:0]         busy_i,
  input  logic [NUM_CH*IDW-1:0]     owner_i,
  output logic [NUM_CH-1:0]         clr_o,
  output logic [NUM_REQ-1:0]        err_o
);
  always_comb begin
    clr_o = '0;
    err_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (rel_req_i[r] && rel_mask_i[r*NUM_CH+c]) begin
          if (busy_i[c] && owner_i[c*IDW +: IDW] == IDW'(r)) clr_o[c] = 1'b1;
          else                                               err_o[r] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vc_rsv_arb.sv
module vc_rsv_arb
  import vc_rsv_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int NUM_CH  = 12,
  parameter int IDW     = 4
) (
  input  logic [NUM_REQ-1:0]        rsv_req_i,
  input  logic [NUM_REQ*NUM_CH-1:0] rsv_mask_i,
  input  logic [NUM_CH-1:0]         busy_i,
  input  logic [IDW-1:0]            ptr_i,
  output logic [NUM_REQ-1:0]        gnt_o,
  output logic [NUM_CH-1:0]         set_o,
  output logic [NUM_CH*IDW-1:0]     set_owner_o,
  output logic                      any_o,
  output logic [IDW-1:0]            next_ptr_o
);
  logic [NUM_CH-1:0] m;
  int idx;

  // greedy scan from pointer; earlier winners block later overlapping masks
  always_comb begin
    gnt_o       = '0;
    set_o       = '0;
    set_owner_o = '0;
    any_o       = 1'b0;
    next_ptr_o  = ptr_i;
    m           = '0;
    idx         = 0;
    for (int k = 0; k < NUM_REQ; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= NUM_REQ) idx = idx - NUM_REQ;
      m = rsv_mask_i[idx*NUM_CH +: NUM_CH];
      if (rsv_req_i[idx] && (m != '0) && ((m & (busy_i | set_o)) == '0)) begin
        gnt_o[idx] = 1'b1;
        set_o      = set_o | m;
        for (int c = 0; c < NUM_CH; c++)
          if (m[c]) set_owner_o[c*IDW +: IDW] = IDW'(idx);
        if (!any_o) begin
          any_o      = 1'b1;
          next_ptr_o = IDW'(rr_next(idx, NUM_REQ));
        end
      end
    end
  end
endmodule

// File: rtl/vc_rsv_state.sv
module vc_rsv_state #(
  parameter int NUM_CH = 12,
  parameter int IDW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     set_i,
  input  logic [NUM_CH*IDW-1:0] set_owner_i,
  input  logic [NUM_CH-1:0]     clr_i,
  output logic [NUM_CH-1:0]     busy_o,
  output logic [NUM_CH*IDW-1:0] owner_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic           busy_q;
    logic [IDW-1:0] own_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        own_q  <= '0;
      end else if (set_i[c]) begin
        busy_q <= 1'b1;
        own_q  <= set_owner_i[c*IDW +: IDW];
      end else if (clr_i[c]) begin
        busy_q <= 1'b0;
      end
    end
    assign busy_o[c]              = busy_q;
    assign owner_o[c*IDW +: IDW]  = own_q;
  end
endmodule

// File: rtl/vc_rsv_unit.sv
module vc_rsv_unit
  import vc_rsv_pkg::*;
#(
  parameter int NUM_LINKS = DEF_LINKS,
  parameter int VC_PER_LINK = DEF_VCS,
  parameter int NUM_RX  = DEF_RX_REQ,
  parameter int NUM_CH  = NUM_LINKS * VC_PER_LINK,
  parameter int NUM_REQ = NUM_RX + NUM_CH,
  parameter int IDW     = $clog2(NUM_REQ)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        rsv_req_i,
  input  logic [NUM_REQ*NUM_CH-1:0] rsv_mask_i,
  input  logic [NUM_REQ-1:0]        rel_req_i,
  input  logic [NUM_REQ*NUM_CH-1:0] rel_mask_i,
  output logic [NUM_REQ-1:0]        rsv_gnt_o,
  output logic [NUM_REQ-1:0]        rel_err_o,
  output logic [NUM_CH-1:0]         busy_o,
  output logic [NUM_CH*IDW-1:0]     owner_o
);
  logic [NUM_CH-1:0]     clr, set;
  logic [NUM_CH*IDW-1:0] set_owner;
  logic [NUM_REQ-1:0]    gnt, err;
  logic                  any;
  logic [IDW-1:0]        ptr_q, ptr_d;

  vc_rsv_release #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .IDW(IDW)) u_rel (
    .rel_req_i (rel_req_i),
    .rel_mask_i(rel_mask_i),
    .busy_i    (busy_o),
    .owner_i   (owner_o),
    .clr_o     (clr),
    .err_o     (err)
  );

  // arbitration sees pre-release state: a freed channel is grantable next cycle
  vc_rsv_arb #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .IDW(IDW)) u_arb (
    .rsv_req_i  (rsv_req_i),
    .rsv_mask_i (rsv_mask_i),
    .busy_i     (busy_o),
    .ptr_i      (ptr_q),
    .gnt_o      (gnt),
    .set_o      (set),
    .set_owner_o(set_owner),
    .any_o      (any),
    .next_ptr_o (ptr_d)
  );

  vc_rsv_state #(.NUM_CH(NUM_CH), .IDW(IDW)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set),
    .set_owner_i(set_owner),
    .clr_i      (clr),
    .busy_o     (busy_o),
    .owner_o    (owner_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      rsv_gnt_o <= '0;
      rel_err_o <= '0;
    end else begin
      if (any) ptr_q <= ptr_d;
      rsv_gnt_o <= gnt;
      rel_err_o <= err;
    end
  end
endmodule

// File: rtl/vc_rsv_unit_chk.sv
module vc_rsv_unit_chk #(
  parameter int NUM_REQ = 16,
  parameter int NUM_CH  = 12,
  parameter int IDW     = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_REQ-1:0]        rsv_req_i,
  input logic [NUM_REQ*NUM_CH-1:0] rsv_mask_i,
  input logic [NUM_REQ-1:0]        rel_req_i,
  input logic [NUM_REQ*NUM_CH-1:0] rel_mask_i,
  input logic [NUM_REQ-1:0]        rsv_gnt_o,
  input logic [NUM_REQ-1:0]        rel_err_o,
  input logic [NUM_CH-1:0]         busy_o,
  input logic [NUM_CH*IDW-1:0]     owner_o
);
  logic [NUM_REQ*NUM_CH-1:0]           pm_q;
  logic [NUM_CH-1:0][NUM_REQ-1:0]      col;
  logic [NUM_CH-1:0]                   own_rel;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pm_q <= '0;
    else         pm_q <= rsv_mask_i;

  always_comb begin
    own_rel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        col[c][r] = rsv_gnt_o[r] & pm_q[r*NUM_CH+c];
        if (owner_o[c*IDW +: IDW] == IDW'(r))
          own_rel[c] = rel_req_i[r] & rel_mask_i[r*NUM_CH+c];
      end
    end
  end

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle: assert (busy_o == '0 && rsv_gnt_o == '0 && rel_err_o == '0);

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    a_r9_gnt_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsv_gnt_o[r] |-> ($past(rsv_req_i[r]) && $past(rsv_mask_i[r*NUM_CH +: NUM_CH]) != '0));
    a_r7_err_from_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_err_o[r] |-> $past(rel_req_i[r]));
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      a_r3_gnt_only_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsv_gnt_o[r] && $past(rsv_mask_i[r*NUM_CH+c])) |-> !$past(busy_o[c]));
      a_r2_gnt_takes_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsv_gnt_o[r] && $past(rsv_mask_i[r*NUM_CH+c])) |->
          (busy_o[c] && owner_o[c*IDW +: IDW] == IDW'(r)));
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    a_r4_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col[c]) <= 1);
    a_r7_held_until_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[c] && !own_rel[c]) |=> (busy_o[c] && $stable(owner_o[c*IDW +: IDW])));
    a_r6_owner_release_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[c] && own_rel[c]) |=> !busy_o[c]);
  end
endmodule

bind vc_rsv_unit vc_rsv_unit_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .IDW(IDW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rsv_req_i (rsv_req_i),
  .rsv_mask_i(rsv_mask_i),
  .rel_req_i (rel_req_i),
  .rel_mask_i(rel_mask_i),
  .rsv_gnt_o (rsv_gnt_o),
  .rel_err_o (rel_err_o),
  .busy_o    (busy_o),
  .owner_o   (owner_o)
);

// File: tb/tb_vc_rsv_unit.sv
`timescale 1ns/1ps
module tb_vc_rsv_unit;
  localparam int NR  = 16;
  localparam int NC  = 12;
  localparam int IDW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic [NR-1:0]    rsv_req, rel_req;
  logic [NR*NC-1:0] rsv_mask, rel_mask;
  logic [NR-1:0]    rsv_gnt, rel_err;
  logic [NC-1:0]    busy;
  logic [NC*IDW-1:0] owner;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk_i = ~clk_i;

  vc_rsv_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rsv_req_i(rsv_req), .rsv_mask_i(rsv_mask),
    .rel_req_i(rel_req), .rel_mask_i(rel_mask),
    .rsv_gnt_o(rsv_gnt), .rel_err_o(rel_err),
    .busy_o(busy), .owner_o(owner)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    rsv_req = '0; rel_req = '0; rsv_mask = '0; rel_mask = '0;
  endtask

  task automatic rsv(input int r, input logic [NC-1:0] m);
    rsv_req[r] = 1'b1; rsv_mask[r*NC +: NC] = m;
  endtask

  task automatic rel(input int r, input logic [NC-1:0] m);
    rel_req[r] = 1'b1; rel_mask[r*NC +: NC] = m;
  endtask

  // inputs set at a falling edge; one rising edge later results are sampled
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    clr_in();
  endtask

  function automatic logic [IDW-1:0] own(input int c);
    return owner[c*IDW +: IDW];
  endfunction

  function automatic logic [NR-1:0] bitr(input int r);
    return NR'(1) << r;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clr_in();
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 gnt", 64'(rsv_gnt), 0);
    chk("R1 err", 64'(rel_err), 0);
    chk("R1 owner", 64'(owner), 0);

    // R4 round robin, pointer starts at 0
    rsv(3, 12'h001); rsv(5, 12'h003); step();
    chk("R4 first win", 64'(rsv_gnt), 64'(bitr(3)));
    chk("R4 busy", 64'(busy), 64'h1);
    chk("R4 owner", 64'(own(0)), 3);
    rel(3, 12'h001); step();
    chk("R6 freed", 64'(busy), 0);
    rsv(3, 12'h001); rsv(5, 12'h003); step();
    chk("R4 rotate", 64'(rsv_gnt), 64'(bitr(5)));
    chk("R4 busy2", 64'(busy), 64'h3);
    chk("R4 owner1", 64'(own(1)), 5);
    rel(5, 12'h003); step();
    rsv(3, 12'h001); rsv(5, 12'h003); step();
    chk("R4 wrap", 64'(rsv_gnt), 64'(bitr(3)));
    rel(3, 12'h001); step();

    // R5 disjoint requests all granted
    rsv(0, 12'h00F); rsv(1, 12'h0F0); rsv(2, 12'hF00); step();
    chk("R5 gnt", 64'(rsv_gnt), 64'h7);
    chk("R5 busy", 64'(busy), 64'hFFF);
    chk("R5 owner", 64'(own(11)), 2);
    rel(0, 12'h00F); rel(1, 12'h0F0); rel(2, 12'hF00); step();
    chk("R6 all freed", 64'(busy), 0);
    chk("R6 no err", 64'(rel_err), 0);

    // R3 all or nothing
    rsv(7, 12'h020); step();
    rsv(8, 12'h030); step();
    chk("R3 no gnt", 64'(rsv_gnt), 0);
    chk("R3 untouched", 64'(busy), 64'h020);
    chk("R3 owner kept", 64'(own(5)), 7);
    rsv(8, 12'h010); step();
    chk("R3 partial ok", 64'(rsv_gnt), 64'(bitr(8)));

    // R7 wrong releases
    rel(2, 12'h020); step();
    chk("R7 err", 64'(rel_err), 64'(bitr(2)));
    chk("R7 still busy", 64'(busy), 64'h030);
    chk("R7 owner", 64'(own(5)), 7);
    rel(2, 12'h001); step();
    chk("R7 free err", 64'(rel_err), 64'(bitr(2)));
    chk("R7 free stays", 64'(busy), 64'h030);
    rel(7, 12'h020); rel(8, 12'h010); step();
    chk("R6 both freed", 64'(busy), 0);

    // R8 release and reserve in the same cycle, then next cycle
    rsv(7, 12'h040); step();
    rel(7, 12'h040); rsv(9, 12'h040); step();
    chk("R8 same cycle refused", 64'(rsv_gnt), 0);
    chk("R8 freed", 64'(busy), 0);
    rsv(9, 12'h040); step();
    chk("R8 next cycle", 64'(rsv_gnt), 64'(bitr(9)));
    chk("R8 owner", 64'(own(6)), 9);
    rel(9, 12'h040); step();

    // R9 empty mask
    rsv(4, 12'h000); step();
    chk("R9 no gnt", 64'(rsv_gnt), 0);
    chk("R9 busy", 64'(busy), 0);

    // sweep every channel and requester: R2, R7, R6
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < NR; r++) begin
        int w;
        w = (r + 1) % NR;
        rsv(r, NC'(1) << c); step();
        chk("R2 gnt", 64'(rsv_gnt), 64'(bitr(r)));
        chk("R2 busy", 64'(busy), 64'(1) << c);
        chk("R2 owner", 64'(own(c)), 64'(r));
        rel(w, NC'(1) << c); step();
        chk("R7 sweep err", 64'(rel_err), 64'(bitr(w)));
        chk("R7 sweep busy", 64'(busy), 64'(1) << c);
        rel(r, NC'(1) << c); step();
        chk("R6 sweep free", 64'(busy), 0);
        chk("R6 sweep err", 64'(rel_err), 0);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule